// File: doc/BRIEF.md
# Linear-Phase DC Removal Filter

This block strips the constant component from a stream of signed samples without a multiplier. It smooths the input with a cascade of D-point boxcar averagers and subtracts the smoothed value from a delayed copy of the input. D is a power of two. Each averager is a running sum: a comb of depth D feeding an integrator. The normalisation by D for every stage is applied once, as a single arithmetic right shift at the end of the cascade.

The cascade has an odd number of taps, so its group delay is a whole number of samples. The delayed copy of the input therefore comes straight from a second read port on the first averager's sample ring, and no separate alignment line is needed. A parameter selects two averagers (delay D−1) or four averagers (delay 2D−2). A second parameter chooses how the final difference leaves the block. It can keep one extra bit of width, or it can be clipped back to the input width.

Samples arrive with a valid strobe, and gaps of any length are allowed between them. Each accepted sample produces one registered result on the following clock. The result is flagged valid once the filter's full impulse span has been filled since reset.

Top module: `dc_blocker`

## Requirements
- R1: Once the output is valid, a constant input held for at least one filter span (2D−1 samples in the dual form) produces an output of exactly 0.
- R2: `out_valid` is high on the clock after an accepted sample if and only if that sample's index since reset (first sample = 0) is at least STAGES·(D−1), where STAGES is 2 (dual form) or 4 (four-averager form). It is low on every other cycle.
- R3: For accepted sample n, the output equals x[n−GD] − floor(S/D^STAGES). S is the STAGES-fold cascade of D-point sums of the input. Samples before reset count as zero. GD is D−1 in the dual form.
- R4: With the clipping parameter off, the output is DW+1 bits wide and carries differences beyond the DW-bit range without loss.
- R5: With the four-averager parameter set, GD is 2D−2, the combined shift is 4·log2(D) bits, and R2 and R3 apply with STAGES = 4.
- R6: A cycle with `in_valid` low changes no filter state, holds `out_sample`, and drives `out_valid` low. Results do not depend on gaps between samples.
- R7: Synchronous reset clears the output to 0 and `out_valid` to 0, and it discards all sample history.
- R8: Full-scale inputs (for example a constant of −2^(DW−1)) give results that meet R1 and R3 exactly. Intermediate sums wrap in two's complement without corrupting the result.
- R9: With the clipping parameter on, the output is DW bits wide and any difference outside [−2^(DW−1), 2^(DW−1)−1] is clamped to the nearer end of that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Result strobe, one per accepted sample once the span is filled |
| out_sample | output | OUT_W | Signed result; DW+1 bits, or DW bits when clipping is on |

## Verification
The bench targets the alignment between the delayed tap and the averaged path. An off-by-one tap would leave a residue on a constant input and would misplace every impulse response sample. It also checks the fill count, because a wrong threshold flags garbage as valid or drops good results. A full-scale negative constant checks that sums wrapping in the accumulators still cancel to zero, and a lone positive spike on a full-scale negative floor produces a difference that exceeds the input range. A truncated subtractor would fold that difference to a wrong sign, and missing clamp logic would wrap it in the four-averager, clipped instance. Randomised samples with idle gaps and a mid-stream reset show whether state leaks across bubbles or survives reset.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Bit offset of cascade segment k inside the flattened chain vector.
  // Segment k is DW + k*LOG2D bits wide (raw input is segment 0).
  function automatic int seg_off(input int dw, input int l2d, input int k);
    return k * dw + (l2d * k * (k - 1)) / 2;
  endfunction

  function automatic int stage_count(input bit quad);
    return quad ? 4 : 2;
  endfunction

endpackage

// File: rtl/dcb_ring.sv
module dcb_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  parameter int TAP_A = 32,
  parameter int TAP_B = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [CW-1:0] fill;

  // Storage has no reset so it maps onto RAM; the fill count hides stale words.
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      fill <= '0;
    end else if (push) begin
      wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  // Address of the word written 'off' pushes ago.
  function automatic logic [AW-1:0] back(input logic [AW-1:0] p, input int off);
    int s;
    s = int'(p) + DEPTH - off;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  assign a_q = (int'(fill) >= TAP_A) ? mem[back(wptr, TAP_A)] : '0;
  assign b_q = (int'(fill) >= TAP_B) ? mem[back(wptr, TAP_B)] : '0;

  assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    int'(wptr) < DEPTH);

  assert_ring_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !push |=> ($stable(wptr) && $stable(fill)));

endmodule

// File: rtl/dcb_accum.sv
module dcb_accum #(
  parameter int IW    = 16,
  parameter int LOG2D = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic signed [IW-1:0]      q_in,
  input  logic signed [IW-1:0]      q_old,
  output logic signed [IW+LOG2D-1:0] sum_next
);
  localparam int OW = IW + LOG2D;

  logic signed [OW-1:0] acc;

  // Comb then integrator folded into one running sum; wraps modulo 2^OW.
  assign sum_next = acc + OW'(q_in) - OW'(q_old);

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (push) acc <= sum_next;
  end

  assert_acc_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(acc));

endmodule

// File: rtl/dc_blocker.sv
module dc_blocker
  import dcb_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LOG2D = 5,
  parameter bit QUAD  = 1'b0,
  parameter bit SAT   = 1'b0,
  localparam int OUT_W = SAT ? DW : DW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [DW-1:0]    in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int D      = 1 << LOG2D;
  localparam int STAGES = stage_count(QUAD);
  localparam int GD     = (STAGES / 2) * (D - 1);
  localparam int FILL   = STAGES * (D - 1);
  localparam int RING0  = (GD > D) ? GD : D;
  localparam int SW     = DW + STAGES * LOG2D;
  localparam int SHIFT  = STAGES * LOG2D;
  localparam int TOTW   = seg_off(DW, LOG2D, STAGES + 1);
  localparam int FCW    = $clog2(FILL + 1);

  wire  [TOTW-1:0]       chain_flat;
  logic signed [DW-1:0]  tap_x;
  logic signed [SW-1:0]  fin;
  logic signed [DW-1:0]  avg;
  logic signed [DW:0]    diff;
  logic signed [OUT_W-1:0] out_next;
  logic [FCW-1:0]        seen;

  assign chain_flat[DW-1:0] = in_sample;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int IW = DW + k * LOG2D;
    localparam int OI = seg_off(DW, LOG2D, k);
    localparam int OO = seg_off(DW, LOG2D, k + 1);

    logic signed [IW-1:0]       q_cur;
    logic signed [IW-1:0]       q_old;
    logic signed [IW+LOG2D-1:0] sn;

    assign q_cur = chain_flat[OI +: IW];
    assign chain_flat[OO +: IW + LOG2D] = sn;

    if (k == 0) begin : g_first
      // First ring also supplies the group-delay-aligned input sample.
      dcb_ring #(.W(IW), .DEPTH(RING0), .TAP_A(D), .TAP_B(GD)) u_ring (
        .clk(clk), .rst(rst), .push(in_valid), .din(q_cur),
        .a_q(q_old), .b_q(tap_x));
    end else begin : g_rest
      logic [IW-1:0] tap_unused;
      dcb_ring #(.W(IW), .DEPTH(D), .TAP_A(D), .TAP_B(D)) u_ring (
        .clk(clk), .rst(rst), .push(in_valid), .din(q_cur),
        .a_q(q_old), .b_q(tap_unused));
    end

    dcb_accum #(.IW(IW), .LOG2D(LOG2D)) u_acc (
      .clk(clk), .rst(rst), .push(in_valid),
      .q_in(q_cur), .q_old(q_old), .sum_next(sn));
  end

  assign fin  = chain_flat[seg_off(DW, LOG2D, STAGES) +: SW];
  assign avg  = DW'(fin >>> SHIFT);
  assign diff = (DW + 1)'(tap_x) - (DW + 1)'(avg);

  if (SAT) begin : g_clip
    localparam logic signed [DW:0] HI = {2'b00, {(DW - 1){1'b1}}};
    localparam logic signed [DW:0] LO = {2'b11, {(DW - 1){1'b0}}};
    always_comb begin
      if (diff > HI)      out_next = {1'b0, {(DW - 1){1'b1}}};
      else if (diff < LO) out_next = {1'b1, {(DW - 1){1'b0}}};
      else                out_next = diff[DW-1:0];
    end
  end else begin : g_wide
    assign out_next = diff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      seen       <= '0;
    end else begin
      out_valid <= in_valid && (seen == FCW'(FILL));
      if (in_valid) begin
        out_sample <= out_next;
        if (seen != FCW'(FILL)) seen <= seen + 1'b1;
      end
    end
  end

  assert_valid_needs_input_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_sample) && !out_valid));

endmodule

// File: tb/tb_dc_blocker.sv
module tb_dc_blocker;
  localparam int CLK_PERIOD = 10;

  localparam int D_A = 32, ST_A = 2, GD_A = 31, FILL_A = 62, SH_A = 10;
  localparam int D_Q = 4,  ST_Q = 4, GD_Q = 6,  FILL_Q = 12, SH_Q = 8;
  localparam int NW_A = ST_A * (D_A - 1) + 1;
  localparam int NW_Q = ST_Q * (D_Q - 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] xa_in = '0;
  logic signed [7:0]  xq_in = '0;
  logic va, vq;
  logic signed [16:0] ya;
  logic signed [7:0]  yq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dc_blocker #(.DW(16), .LOG2D(5), .QUAD(1'b0), .SAT(1'b0)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(xa_in),
    .out_valid(va), .out_sample(ya));

  dc_blocker #(.DW(8), .LOG2D(2), .QUAD(1'b1), .SAT(1'b1)) dut_q (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(xq_in),
    .out_valid(vq), .out_sample(yq));

  int n_chk = 0, n_fail = 0;
  longint wa[], wq[], ha[], hq[];
  int na = 0, nq = 0;
  int first_a = -1, first_q = -1;
  longint peak_a, peak_q;
  bit done = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic make_w(input int d, input int st, input int nw, output longint w[]);
    longint t[];
    w = new[nw];
    t = new[nw];
    for (int j = 0; j < nw; j++) w[j] = (j < d) ? 1 : 0;
    for (int s = 1; s < st; s++) begin
      for (int j = 0; j < nw; j++) begin
        t[j] = 0;
        for (int i = 0; i < d; i++) if (j - i >= 0) t[j] += w[j - i];
      end
      for (int j = 0; j < nw; j++) w[j] = t[j];
    end
  endtask

  function automatic longint model(input longint h[], input longint w[],
                                   input int gd, input int sh);
    longint s = 0;
    for (int j = 0; j < h.size(); j++) s += w[j] * h[j];
    return h[gd] - (s >>> sh);
  endfunction

  task automatic clear_model();
    for (int j = 0; j < NW_A; j++) ha[j] = 0;
    for (int j = 0; j < NW_Q; j++) hq[j] = 0;
    na = 0; nq = 0; first_a = -1; first_q = -1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clear_model();
  endtask

  // Drive one sample at a negedge; check results at the following negedge.
  task automatic push(input logic signed [15:0] xa, input logic signed [7:0] xq);
    longint ea, eq;
    bit eva, evq;
    in_valid = 1'b1; xa_in = xa; xq_in = xq;
    for (int j = NW_A - 1; j > 0; j--) ha[j] = ha[j - 1];
    ha[0] = xa;
    for (int j = NW_Q - 1; j > 0; j--) hq[j] = hq[j - 1];
    hq[0] = xq;
    eva = (na >= FILL_A);
    evq = (nq >= FILL_Q);
    ea = model(ha, wa, GD_A, SH_A);
    eq = model(hq, wq, GD_Q, SH_Q);
    if (eq > 127) eq = 127;     // R9 clamp
    if (eq < -128) eq = -128;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 dual valid", longint'(va), longint'(eva));
    check("R5 quad valid", longint'(vq), longint'(evq));
    if (va && first_a < 0) first_a = na;
    if (vq && first_q < 0) first_q = nq;
    if (eva) begin
      check("R3 dual value", longint'(ya), ea);
      if (longint'(ya) > peak_a) peak_a = longint'(ya);
    end
    if (evq) begin
      check("R5 quad value", longint'(yq), eq);
      if (longint'(yq) > peak_q) peak_q = longint'(yq);
    end
    na++; nq++;
  endtask

  task automatic idle(input int n);
    longint pa, pq;
    for (int i = 0; i < n; i++) begin
      pa = longint'(ya); pq = longint'(yq);
      @(posedge clk);
      @(negedge clk);
      check("R6 idle hold dual", longint'(ya), pa);
      check("R6 idle hold quad", longint'(yq), pq);
      check("R6 idle no valid", longint'(va | vq), 0);
    end
  endtask

  task automatic t_reset_state();
    check("R7 reset valid", longint'(va | vq), 0);
    check("R7 reset dual out", longint'(ya), 0);
    check("R7 reset quad out", longint'(yq), 0);
  endtask

  task automatic t_constant();
    for (int i = 0; i < 100; i++) push(16'sd1200, 8'sd4);
    check("R2 dual first valid index", first_a, FILL_A);
    check("R5 quad first valid index", first_q, FILL_Q);
    check("R1 dual dc null", longint'(ya), 0);
    check("R1 quad dc null", longint'(yq), 0);
  endtask

  task automatic t_fullscale();
    for (int i = 0; i < 80; i++) push(-16'sd32768, -8'sd128);
    check("R8 dual full-scale null", longint'(ya), 0);
    check("R8 quad full-scale null", longint'(yq), 0);
  endtask

  task automatic t_impulse();
    peak_a = -100000; peak_q = -1000;
    push(16'sd32767, 8'sd127);
    for (int i = 0; i < 70; i++) push(-16'sd32768, -8'sd128);
    check("R4 wide peak beyond DW range", longint'(peak_a > 32767), 1);
    check("R9 clamp at upper rail", peak_q, 127);
  endtask

  task automatic t_gaps();
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 120; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      push($signed(lf) >>> 1, $signed(lf[15:8]) >>> 1);
      idle(i % 3);
    end
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 10; i++) push(16'sd9000, 8'sd35);
    do_reset();
    t_reset_state();
    for (int i = 0; i < 70; i++) push(-16'sd500, -8'sd2);
    check("R7 dual refill index", first_a, FILL_A);
    check("R7 quad refill index", first_q, FILL_Q);
    check("R1 dc null after reset", longint'(ya), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    make_w(D_A, ST_A, NW_A, wa);
    make_w(D_Q, ST_Q, NW_Q, wq);
    ha = new[NW_A];
    hq = new[NW_Q];
    clear_model();
    do_reset();
    t_reset_state();
    t_constant();
    t_fullscale();
    t_impulse();
    t_gaps();
    t_midreset();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule